// File: doc/BRIEF.md
# Per-Core Clock-Ratio Mode Controller

This unit sits beside one processor core and decides how often that core may advance. It runs on the full-rate system clock and emits a one-cycle core enable that fires once every N system cycles. N is an integer taken from a small built-in table of operating modes. Each mode also carries a supply-level code. The code and the divide ratio always switch on the same clock edge, so the core never sees one without the other. Each core has its own instance, and each instance is controlled on its own.

Software asks for a new mode through a valid/ready request channel. A request is accepted when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` stays low from the edge that accepts a real change until that change has taken effect. This is the only back-pressure. A request presented while ready is low is neither taken nor remembered. An accepted mode waits for the end of the current divided period, so no core cycle is ever shortened. After the switch, the enable stays low for a fixed settle window. A bank of saturating counters records how many core cycles were run in each mode. Any one of them can be read combinationally through a select input, for energy accounting later. The request and readback side always runs at the system clock, whatever mode is active.

Top module: `core_ratio_ctrl`

## Requirements
- R1: While reset is held, `active_mode` is 0, `vdd_code` is NUM_MODES-1, `req_ready` is 1 and every residency counter reads 0. The block leaves reset in mode 0.
- R2: Outside a settle window, `core_en` is high for exactly one cycle in every N system cycles. N depends on the active mode. With the default table, mode 0 gives 1, mode 1 gives 2, mode 2 gives 3, and mode 3 (the last mode) gives MAX_RATIO = 5.
- R3: `vdd_code` equals NUM_MODES-1-`active_mode`, so mode 0 has the highest code. It changes only on the same edge as `active_mode`.
- R4: A new mode takes effect only on the edge that ends a cycle in which `core_en` was high under the old mode. No divided period is cut short.
- R5: After a switch, `core_en` stays low for SETTLE cycles. The first enable under the new mode comes exactly SETTLE+N_new cycles after the last enable under the old mode.
- R6: Once a change is accepted, `req_ready` is low until the edge on which `active_mode` changes, and high on the cycle after that edge. Requests made while ready is low have no effect on the mode.
- R7: A request for the mode that is already active is accepted but changes nothing. `req_ready` stays high, no settle window is inserted, and the enable cadence is not disturbed.
- R8: The counter of mode m increases by one on each edge where `core_en` is high and `active_mode` is m. `rd_data` shows the counter chosen by `rd_sel`.
- R9: A counter that reaches all-ones holds that value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mode | input | MODE_W | Requested mode index |
| core_en | output | 1 | One-cycle enable for the core's divided clock |
| active_mode | output | MODE_W | Mode currently in force |
| vdd_code | output | VCODE_W | Supply-level code paired with the active mode |
| rd_sel | input | MODE_W | Selects which residency counter to read |
| rd_data | output | CNT_W | Selected residency count |

## Verification
A divider count that is out of step shows up as an enable interval that is not N. The bench sees this within one period of the active mode. A wrong pending or settle state changes the gap between the last old enable and the first new one, or leaves `req_ready` wrong on the cycle after acceptance, so these errors show up within SETTLE+N cycles of a request. A residency counter that counts the wrong thing diverges from a tally of port-observed enables as soon as the counter is read. A counter that wraps shows it at the first read after its all-ones limit is passed.

// File: rtl/core_ratio_pkg.sv
package core_ratio_pkg;
  // divide ratio of a mode: fastest first, the last mode runs slowest
  function automatic int ratio_of(int m, int n_modes, int max_ratio);
    return (m == n_modes - 1) ? max_ratio : m + 1;
  endfunction

  // supply code paired with a mode: highest code for the fastest mode
  function automatic int vcode_of(int m, int n_modes);
    return n_modes - 1 - m;
  endfunction
endpackage

// File: rtl/mcr_mode_seq.sv
module mcr_mode_seq #(
  parameter int NUM_MODES = 4,
  parameter int MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              boundary,
  output logic              req_ready,
  output logic [MODE_W-1:0] active_mode,
  output logic              switch_now
);
  logic              pend_q;
  logic [MODE_W-1:0] pend_mode_q;
  logic [MODE_W-1:0] mode_q;
  logic              take;

  assign req_ready   = ~pend_q;
  assign take        = req_valid & ~pend_q;
  assign switch_now  = pend_q & boundary;
  assign active_mode = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_mode_q <= '0;
      mode_q      <= '0;
    end else if (switch_now) begin
      mode_q <= pend_mode_q;
      pend_q <= 1'b0;
    end else if (take && (req_mode != mode_q)) begin
      pend_q      <= 1'b1;
      pend_mode_q <= req_mode;
    end
  end
endmodule

// File: rtl/mcr_divider.sv
module mcr_divider #(
  parameter int MAX_RATIO = 5,
  parameter int SETTLE    = 3,
  parameter int DIV_W     = $clog2(MAX_RATIO + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio,
  input  logic             switch_now,
  output logic             core_en
);
  localparam int SET_W = $clog2(SETTLE + 2);

  logic [DIV_W-1:0] div_q;
  logic             idle;
  logic             last;

  generate
    if (SETTLE > 0) begin : g_settle
      logic [SET_W-1:0] set_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              set_q <= '0;
        else if (switch_now)     set_q <= SET_W'(SETTLE);
        else if (set_q != '0)    set_q <= set_q - 1'b1;
      end
      assign idle = (set_q == '0);
    end else begin : g_nosettle
      assign idle = 1'b1;
    end
  endgenerate

  assign last    = (div_q == DIV_W'(ratio - 1'b1));
  assign core_en = idle & last;

  always_ff @(posedge clk) begin
    if (!rst_n)                          div_q <= '0;
    else if (switch_now || !idle || last) div_q <= '0;
    else                                 div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/mcr_residency.sv
module mcr_residency #(
  parameter int NUM_MODES = 4,
  parameter int MODE_W    = 2,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  input  logic [MODE_W-1:0] rd_sel,
  output logic [CNT_W-1:0]  rd_data
);
  logic [CNT_W-1:0] cnt [NUM_MODES];

  generate
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt[g] <= '0;
        else if (tick && (mode == MODE_W'(g)) && (cnt[g] != '1))
          cnt[g] <= cnt[g] + 1'b1;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_MODES; i++)
      if (rd_sel == MODE_W'(i)) rd_data = cnt[i];
  end
endmodule

// File: rtl/core_ratio_ctrl.sv
module core_ratio_ctrl #(
  parameter int NUM_MODES = 4,
  parameter int MAX_RATIO = 5,
  parameter int SETTLE    = 3,
  parameter int CNT_W     = 32,
  parameter int VCODE_W   = 3,
  parameter int MODE_W    = $clog2(NUM_MODES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [MODE_W-1:0]  req_mode,
  output logic               core_en,
  output logic [MODE_W-1:0]  active_mode,
  output logic [VCODE_W-1:0] vdd_code,
  input  logic [MODE_W-1:0]  rd_sel,
  output logic [CNT_W-1:0]   rd_data
);
  import core_ratio_pkg::*;

  localparam int DIV_W = $clog2(MAX_RATIO + 1);

  logic [DIV_W-1:0] act_ratio;
  logic             switch_now;

  assign act_ratio = DIV_W'(ratio_of(int'(active_mode), NUM_MODES, MAX_RATIO));
  assign vdd_code  = VCODE_W'(vcode_of(int'(active_mode), NUM_MODES));

  mcr_mode_seq #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .boundary(core_en), .req_ready(req_ready), .active_mode(active_mode),
    .switch_now(switch_now)
  );

  mcr_divider #(.MAX_RATIO(MAX_RATIO), .SETTLE(SETTLE), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ratio(act_ratio), .switch_now(switch_now),
    .core_en(core_en)
  );

  mcr_residency #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W), .CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .tick(core_en), .mode(active_mode),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );
endmodule

// File: rtl/core_ratio_ctrl_chk.sv
module core_ratio_ctrl_chk #(
  parameter int SETTLE  = 3,
  parameter int CNT_W   = 32,
  parameter int VCODE_W = 3,
  parameter int MODE_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [MODE_W-1:0]  req_mode,
  input logic               core_en,
  input logic [MODE_W-1:0]  active_mode,
  input logic [VCODE_W-1:0] vdd_code,
  input logic [MODE_W-1:0]  rd_sel,
  input logic [CNT_W-1:0]   rd_data
);
  // R4: a mode changes only right after an enable cycle
  p_switch_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_mode) |-> $past(core_en));

  // R5: the settle window starts on the switch
  generate
    if (SETTLE > 0) begin : g_settle_chk
      p_settle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_mode) |-> !core_en);
    end
  endgenerate

  // R3: supply code moves only together with the mode
  p_vdd_with_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vdd_code) |-> !$stable(active_mode));

  // R6: a real change blocks further requests
  p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mode != active_mode)) |=> !req_ready);

  // R7: same-mode request leaves everything as is
  p_same_mode_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mode == active_mode)) |=> (req_ready && $stable(active_mode)));

  // R8: counters move only on enable cycles
  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> ((rd_sel != $past(rd_sel)) || $stable(rd_data)));

  // R9: saturated counter stays saturated
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&rd_data) |=> ((rd_sel != $past(rd_sel)) || (&rd_data)));
endmodule

bind core_ratio_ctrl core_ratio_ctrl_chk #(
  .SETTLE(SETTLE), .CNT_W(CNT_W), .VCODE_W(VCODE_W), .MODE_W(MODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .core_en(core_en), .active_mode(active_mode),
  .vdd_code(vdd_code), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/core_ratio_ctrl_bench.sv
module core_ratio_ctrl_bench;
  localparam int NM = 4, MAXR = 5, SET = 3, CW = 8, VW = 3, MW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [MW-1:0] req_mode = '0;
  logic          core_en;
  logic [MW-1:0] active_mode;
  logic [VW-1:0] vdd_code;
  logic [MW-1:0] rd_sel = '0;
  logic [CW-1:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int tally [NM];
  bit pend_v = 0;
  int pend_m = 0;

  core_ratio_ctrl #(.NUM_MODES(NM), .MAX_RATIO(MAXR), .SETTLE(SET), .CNT_W(CW),
                    .VCODE_W(VW)) u_core_ratio_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .core_en(core_en), .active_mode(active_mode),
    .vdd_code(vdd_code), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  // port-level tally of enables per mode, committed one cycle late like a register
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) tally[i] = 0;
      pend_v = 0;
    end else begin
      if (pend_v && tally[pend_m] < (1 << CW) - 1) tally[pend_m]++;
      pend_v = core_en;
      pend_m = int'(active_mode);
    end
  end

  function automatic int exp_ratio(int m);
    return (m == NM - 1) ? MAXR : m + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_pulse(output int t);
    int g = 0;
    do begin step(); g++; end while (!core_en && g < 100);
    t = cyc;
  endtask

  task automatic request(int m);
    int g = 0;
    step();
    req_valid = 1'b1;
    req_mode  = MW'(m);
    while (!req_ready && g < 100) begin step(); g++; end
    step();
    req_valid = 1'b0;
  endtask

  // switch to a new mode and check timing of the hand-over
  task automatic do_switch(int m);
    int old_m, t_old, t_new, g;
    bit prev_en;
    old_m = int'(active_mode);
    request(m);
    check(!req_ready, "R6 ready low while pending", int'(req_ready), 0);
    t_old = -1; prev_en = 0; g = 0;
    while (int'(active_mode) != m && g < 100) begin
      if (core_en) t_old = cyc;
      prev_en = core_en;
      step(); g++;
    end
    check(prev_en, "R4 switch right after old enable", int'(prev_en), 1);
    check(int'(vdd_code) == NM - 1 - m, "R3 vdd code of new mode", int'(vdd_code), NM - 1 - m);
    check(!core_en, "R5 enable low at settle start", int'(core_en), 0);
    check(req_ready, "R6 ready back after switch", int'(req_ready), 1);
    wait_pulse(t_new);
    check(t_new - t_old == SET + exp_ratio(m), "R5 gap old-to-new enable",
          t_new - t_old, SET + exp_ratio(m));
    if (old_m == m) check(0, "R6 bench setup", old_m, m);
  endtask

  task automatic t_period(int m);
    int t1, t2, t3;
    wait_pulse(t1); wait_pulse(t2); wait_pulse(t3);
    check(t2 - t1 == exp_ratio(m), "R2 enable interval", t2 - t1, exp_ratio(m));
    check(t3 - t2 == exp_ratio(m), "R2 enable interval", t3 - t2, exp_ratio(m));
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) step();
    check(active_mode == '0, "R1 reset mode", int'(active_mode), 0);
    check(int'(vdd_code) == NM - 1, "R1 reset vdd code", int'(vdd_code), NM - 1);
    check(req_ready, "R1 reset ready", int'(req_ready), 1);
    for (int i = 0; i < NM; i++) begin
      rd_sel = MW'(i);
      #1;
      check(rd_data == '0, "R1 reset counter", int'(rd_data), 0);
    end
    rd_sel = '0;
    rst_n = 1'b1;
    step();
    check(active_mode == '0, "R1 leaves reset in mode 0", int'(active_mode), 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 300; i++) step();
    rd_sel = '0;
    #1;
    check(int'(rd_data) == (1 << CW) - 1, "R9 counter saturates", int'(rd_data), (1 << CW) - 1);
    check(int'(rd_data) == tally[0], "R8 mode 0 count", int'(rd_data), tally[0]);
  endtask

  task automatic t_same_mode();
    int t1, t2, t3;
    wait_pulse(t1);
    request(int'(active_mode));
    check(req_ready, "R7 ready stays high", int'(req_ready), 1);
    wait_pulse(t2); wait_pulse(t3);
    check((t2 - t1) % 3 == 0, "R7 cadence undisturbed", t2 - t1, 3);
    check(t3 - t2 == 3, "R7 no settle inserted", t3 - t2, 3);
    check(active_mode == 2'd2, "R7 mode unchanged", int'(active_mode), 2);
  endtask

  task automatic t_backpressure();
    int t, g;
    wait_pulse(t);
    request(1);
    req_valid = 1'b1;
    req_mode  = 2'd2;
    for (int i = 0; i < 2; i++) begin
      check(!req_ready, "R6 back-pressure while pending", int'(req_ready), 0);
      step();
    end
    req_valid = 1'b0;
    g = 0;
    while (active_mode == 2'd3 && g < 50) begin step(); g++; end
    wait_pulse(t); wait_pulse(t);
    check(active_mode == 2'd1, "R6 blocked request ignored", int'(active_mode), 1);
  endtask

  task automatic t_counters();
    step();
    for (int i = 0; i < NM; i++) begin
      rd_sel = MW'(i);
      #1;
      check(int'(rd_data) == tally[i], "R8 residency count", int'(rd_data), tally[i]);
    end
  endtask

  initial begin
    t_reset();
    t_saturate();
    t_period(0);
    do_switch(1); t_period(1);
    do_switch(2); t_period(2);
    t_same_mode();
    t_counters();
    do_switch(3); t_period(3);
    t_backpressure();
    do_switch(0); t_period(0);
    t_counters();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule